// File: doc/BRIEF.md
# External Interrupt Edge Controller

This block watches a set of external interrupt pins (two by default) and requests an interrupt from the core when a pin shows the chosen edge. Each pin is passed through a synchronizer, and its edge is found by comparing the synchronized level with the level one clock earlier. A detected edge sets a pending flag for that pin. The flag stays set until the core acknowledges that pin, and it is set even while interrupts are disabled.

One bit in the control register selects the active edge, rising or falling, and that bit applies to every pin. The block also holds a global interrupt-enable flag. The enable-interrupt and return-from-interrupt strobes set it. The disable-interrupt strobe clears it, and so does the core's acceptance of any interrupt. Software can read the flag in the control register, but a register write never changes it. The request output is high only when some pin is pending and the global enable is set.

Top module: `ext_irq_edge_ctrl`

## Requirements
- R1: With the edge-select bit at 0, a low-to-high change on a pin sets that pin's pending flag. A pin change applied before clock edge n shows on `pend_o` after clock edge n+2.
- R2: With the edge-select bit at 1, a high-to-low change on a pin sets that pin's pending flag, with the same latency as R1.
- R3: The edge-select bit is bit 7 of the control register and covers all pins. A read returns the edge-select bit in bit 7, the global enable in bit 6 and 0 in bits 5 to 0.
- R4: An enable strobe or a return strobe sets the global enable at the next clock edge.
- R5: A disable strobe, or any bit of `ack_i` (acceptance by the core), clears the global enable at the next clock edge.
- R6: A control register write takes bit 7 and leaves the global enable unchanged, whatever value is in bit 6.
- R7: A pending flag is set whatever the global enable is, and stays set until its `ack_i` bit is high at a clock edge. If a new edge on the same pin is detected at that same edge, the flag stays set.
- R8: `irq_o` is 1 exactly when at least one pending flag is set and the global enable is 1, and it follows the registered state in the same cycle.
- R9: A disable strobe or an acknowledge wins over an enable or return strobe given in the same cycle, so the global enable ends up 0.
- R10: After a synchronous reset the pending flags, the global enable, the edge-select bit and `irq_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_pin_i | input | NUM_PINS | Asynchronous external interrupt pins |
| ctl_wr_i | input | 1 | Control register write strobe |
| ctl_wdata_i | input | 8 | Control register write data; only bit 7 is taken |
| ctl_rdata_o | output | 8 | Control register readback: bit 7 edge select, bit 6 global enable |
| en_stb_i | input | 1 | Enable-interrupt strobe from the core |
| ret_stb_i | input | 1 | Return-from-interrupt strobe from the core |
| dis_stb_i | input | 1 | Disable-interrupt strobe from the core |
| ack_i | input | NUM_PINS | Per-pin acknowledge; any set bit also means the core has accepted an interrupt |
| pend_o | output | NUM_PINS | Per-pin pending flags |
| irq_o | output | 1 | Interrupt request to the core |

## Verification
Two pairs of events can meet in one cycle. A set and a clear of the global enable can arrive together, and the acknowledge of a pin can arrive at the very edge where a new edge on that pin is detected. The bench forces both cases directly: it fires the disable strobe or an acknowledge together with the enable or return strobe, and it times an acknowledge to the third clock after a pin change. Random traffic then hits the same cases again. A behavioural model, built from pin history and simple priority rules, judges every cycle and decides whether the flag survives.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;
  localparam int CTL_W    = 8;
  localparam int EDGE_BIT = 7;
  localparam int GIE_BIT  = 6;

  typedef enum logic {
    EDGE_RISE = 1'b0,
    EDGE_FALL = 1'b1
  } edge_sel_e;
endpackage

// File: rtl/ext_irq_sync.sv
module ext_irq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q <= '0;
    else     chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/ext_irq_edge_pend.sv
module ext_irq_edge_pend
  import ext_irq_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      lvl_i,
  input  edge_sel_e sel_i,
  input  logic      ack_i,
  output logic      pend_o,
  output logic      pend_nxt_o
);
  logic prev_q;
  logic pend_q;
  logic hit;

  always_comb begin
    if (sel_i == EDGE_FALL) hit = prev_q & ~lvl_i;
    else                    hit = lvl_i & ~prev_q;
    pend_nxt_o = hit | (pend_q & ~ack_i);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      prev_q <= lvl_i;
      pend_q <= pend_nxt_o;
    end
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/ext_irq_gie.sv
module ext_irq_gie (
  input  logic clk,
  input  logic rst,
  input  logic set_a_i,
  input  logic set_b_i,
  input  logic clr_a_i,
  input  logic clr_b_i,
  output logic gie_o,
  output logic gie_nxt_o
);
  logic gie_q;

  always_comb begin
    if (clr_a_i || clr_b_i)      gie_nxt_o = 1'b0;
    else if (set_a_i || set_b_i) gie_nxt_o = 1'b1;
    else                         gie_nxt_o = gie_q;
  end

  always_ff @(posedge clk) begin
    if (rst) gie_q <= 1'b0;
    else     gie_q <= gie_nxt_o;
  end

  assign gie_o = gie_q;
endmodule

// File: rtl/ext_irq_edge_ctrl.sv
module ext_irq_edge_ctrl
  import ext_irq_pkg::*;
#(
  parameter int NUM_PINS    = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PINS-1:0] irq_pin_i,
  input  logic                ctl_wr_i,
  input  logic [CTL_W-1:0]    ctl_wdata_i,
  output logic [CTL_W-1:0]    ctl_rdata_o,
  input  logic                en_stb_i,
  input  logic                ret_stb_i,
  input  logic                dis_stb_i,
  input  logic [NUM_PINS-1:0] ack_i,
  output logic [NUM_PINS-1:0] pend_o,
  output logic                irq_o
);
  edge_sel_e           sel_q;
  logic [NUM_PINS-1:0] lvl;
  logic [NUM_PINS-1:0] pend_nxt;
  logic                gie;
  logic                gie_nxt;
  logic                irq_q;
  logic                unused_wdata;

  // only the edge-select bit is writable; the rest, including the flag bit, is dropped
  assign unused_wdata = ^{ctl_wdata_i[EDGE_BIT-1:0]};

  always_ff @(posedge clk) begin
    if (rst)           sel_q <= EDGE_RISE;
    else if (ctl_wr_i) sel_q <= edge_sel_e'(ctl_wdata_i[EDGE_BIT]);
  end

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    ext_irq_sync #(.STAGES(SYNC_STAGES)) sync_i (
      .clk (clk),
      .rst (rst),
      .d_i (irq_pin_i[p]),
      .q_o (lvl[p])
    );

    ext_irq_edge_pend pend_i (
      .clk        (clk),
      .rst        (rst),
      .lvl_i      (lvl[p]),
      .sel_i      (sel_q),
      .ack_i      (ack_i[p]),
      .pend_o     (pend_o[p]),
      .pend_nxt_o (pend_nxt[p])
    );
  end

  ext_irq_gie gie_i (
    .clk       (clk),
    .rst       (rst),
    .set_a_i   (en_stb_i),
    .set_b_i   (ret_stb_i),
    .clr_a_i   (dis_stb_i),
    .clr_b_i   (|ack_i),
    .gie_o     (gie),
    .gie_nxt_o (gie_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= (|pend_nxt) & gie_nxt;
  end

  assign irq_o = irq_q;

  always_comb begin
    ctl_rdata_o           = '0;
    ctl_rdata_o[EDGE_BIT] = sel_q;
    ctl_rdata_o[GIE_BIT]  = gie;
  end
endmodule

// File: rtl/ext_irq_edge_ctrl_chk.sv
module ext_irq_edge_ctrl_chk
  import ext_irq_pkg::*;
#(
  parameter int NUM_PINS = 2
) (
  input logic                clk,
  input logic                rst,
  input logic                ctl_wr_i,
  input logic [CTL_W-1:0]    ctl_rdata_o,
  input logic                en_stb_i,
  input logic                ret_stb_i,
  input logic                dis_stb_i,
  input logic [NUM_PINS-1:0] ack_i,
  input logic [NUM_PINS-1:0] pend_o,
  input logic                irq_o
);
  // R10
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (pend_o == '0 && !irq_o && ctl_rdata_o == '0));

  // R4
  gie_set_chk: assert property (@(posedge clk) disable iff (rst)
    ((en_stb_i || ret_stb_i) && !dis_stb_i && ack_i == '0) |=> ctl_rdata_o[GIE_BIT]);

  // R5
  gie_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (dis_stb_i || ack_i != '0) |=> !ctl_rdata_o[GIE_BIT]);

  // R6
  gie_wr_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (ctl_wr_i && !en_stb_i && !ret_stb_i && !dis_stb_i && ack_i == '0)
      |=> $stable(ctl_rdata_o[GIE_BIT]));

  // R7
  pend_hold_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((pend_o & $past(pend_o & ~ack_i)) == $past(pend_o & ~ack_i)));

  // R8
  irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
    irq_o == (ctl_rdata_o[GIE_BIT] && pend_o != '0));

  // R3
  rdata_zero_chk: assert property (@(posedge clk) disable iff (rst)
    ctl_rdata_o[GIE_BIT-1:0] == '0);
endmodule

bind ext_irq_edge_ctrl ext_irq_edge_ctrl_chk #(.NUM_PINS(NUM_PINS)) chk_i (
  .clk         (clk),
  .rst         (rst),
  .ctl_wr_i    (ctl_wr_i),
  .ctl_rdata_o (ctl_rdata_o),
  .en_stb_i    (en_stb_i),
  .ret_stb_i   (ret_stb_i),
  .dis_stb_i   (dis_stb_i),
  .ack_i       (ack_i),
  .pend_o      (pend_o),
  .irq_o       (irq_o)
);

// File: tb/ext_irq_edge_ctrl_tb_top.sv
module ext_irq_edge_ctrl_tb_top;
  localparam int NP = 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NP-1:0] pin = '0;
  logic          wr = 1'b0;
  logic [7:0]    wdata = '0;
  logic [7:0]    rdata;
  logic          en = 1'b0, ret = 1'b0, dis = 1'b0;
  logic [NP-1:0] ack = '0;
  logic [NP-1:0] pend;
  logic          irq;

  int checks = 0;
  int fails  = 0;
  string tag = "R10";

  always #5 clk = ~clk;

  ext_irq_edge_ctrl #(.NUM_PINS(NP)) dut_i (
    .clk(clk), .rst(rst), .irq_pin_i(pin), .ctl_wr_i(wr), .ctl_wdata_i(wdata),
    .ctl_rdata_o(rdata), .en_stb_i(en), .ret_stb_i(ret), .dis_stb_i(dis),
    .ack_i(ack), .pend_o(pend), .irq_o(irq)
  );

  // behavioural reference: pin history queue (newest first) and flag rules
  logic [NP-1:0] hist[$];
  logic [NP-1:0] m_pend;
  logic          m_gie, m_sel;

  initial begin
    hist = '{'0, '0, '0};
    m_pend = '0; m_gie = 1'b0; m_sel = 1'b0;
  end

  always @(posedge clk) begin
    if (rst) begin
      hist = '{'0, '0, '0};
      m_pend = '0; m_gie = 1'b0; m_sel = 1'b0;
    end else begin
      logic [NP-1:0] now_lvl, old_lvl, hit;
      now_lvl = hist[1];
      old_lvl = hist[2];
      hit = m_sel ? (old_lvl & ~now_lvl) : (now_lvl & ~old_lvl);
      m_pend = hit | (m_pend & ~ack);
      if (dis || ack != 0) m_gie = 1'b0;
      else if (en || ret)  m_gie = 1'b1;
      if (wr) m_sel = wdata[7];
      hist.push_front(pin);
      void'(hist.pop_back());
    end
  end

  task automatic chk(string what, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare();
    logic [7:0] exp_rd;
    exp_rd = 8'h00;
    exp_rd[7] = m_sel;
    exp_rd[6] = m_gie;
    chk("pend", 8'(pend), 8'(m_pend));
    chk("rdata", rdata, exp_rd);
    chk("irq", 8'(irq), 8'((m_pend != 0) && m_gie));
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    compare();
    wr = 1'b0; en = 1'b0; ret = 1'b0; dis = 1'b0; ack = '0;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog R10 actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    // R10: reset state, with pins high to check nothing leaks through
    pin = '1;
    ticks(3);
    tag = "R10";
    chk("reset pend", 8'(pend), 8'h00);
    chk("reset rdata", rdata, 8'h00);
    chk("reset irq", 8'(irq), 8'h00);
    pin = '0;
    rst = 1'b0;
    ticks(4);

    // R1: rising edges, pin 0 then pin 1, with the enable off
    tag = "R1";
    pin[0] = 1'b1; ticks(4);
    pin[1] = 1'b1; ticks(4);
    // R7: pending stays while disabled, then per-pin acknowledge clears it
    tag = "R7";
    ticks(2);
    ack = 2'b01; ticks(2);
    ack = 2'b10; ticks(2);

    // R4: enable strobe, then return strobe after a disable
    tag = "R4";
    en = 1'b1; ticks(2);
    dis = 1'b1; tick();
    ret = 1'b1; ticks(2);

    // R6: writes carrying either value in bit 6 leave the flag alone
    tag = "R6";
    wr = 1'b1; wdata = 8'h00; ticks(2);
    dis = 1'b1; tick();
    wr = 1'b1; wdata = 8'h40; ticks(2);

    // R3/R2: falling edge mode selected through bit 7, applies to both pins
    tag = "R3";
    wr = 1'b1; wdata = 8'hBF; ticks(2);
    tag = "R2";
    en = 1'b1; tick();
    pin = 2'b00; ticks(4);

    // R8: request follows pending and enable together
    tag = "R8";
    ticks(2);
    ack = 2'b01; ticks(2);
    en = 1'b1; ticks(2);
    ack = 2'b10; ticks(2);

    // R5: disable strobe, then acknowledge as acceptance
    tag = "R5";
    en = 1'b1; tick();
    dis = 1'b1; ticks(2);
    en = 1'b1; tick();
    ack = 2'b01; ticks(2);

    // R9: conflicting strobes in one cycle
    tag = "R9";
    en = 1'b1; tick();
    en = 1'b1; dis = 1'b1; ticks(2);
    ret = 1'b1; dis = 1'b1; ticks(2);
    ret = 1'b1; ack = 2'b10; ticks(2);

    // R7: acknowledge in the same cycle a new edge is detected keeps the flag
    tag = "R7";
    wr = 1'b1; wdata = 8'h00; tick();
    pin[0] = 1'b1; ticks(2);
    ack = 2'b01; tick();
    ticks(3);

    // random mixed traffic
    tag = "R1/R2/R8";
    for (int i = 0; i < 3000; i++) begin
      pin = ($urandom_range(0, 3) == 0) ? NP'($urandom) : pin;
      en  = ($urandom_range(0, 7) == 0);
      ret = ($urandom_range(0, 9) == 0);
      dis = ($urandom_range(0, 9) == 0);
      ack = ($urandom_range(0, 5) == 0) ? NP'($urandom) : '0;
      wr  = ($urandom_range(0, 40) == 0);
      wdata = 8'($urandom);
      tick();
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule